// File: doc/BRIEF.md
# PCI Target Address Decoder with Six Base Registers

This block is the address-claim front end of a conventional PCI target function. It holds six 32-bit base address registers. A parameter sets each slot as a 32-bit memory window, a 64-bit memory window (which also takes the next slot as its upper dword), an I/O window, or unused. Configuration software writes a base into a slot. Writing all ones and reading the slot back returns the window's size mask, with the hardwired type bits still in place.

The block watches FRAME#, AD and C/BE# on the bus. It captures the address and command on the clock where FRAME# first goes low on an idle bus. For a dual address cycle it also captures the high dword one clock later. It then compares the address against every window whose command class and space enable match. On a hit it drives DEVSEL# low at fast, medium or slow timing. If no window matches and subtractive mode is on, it claims late, but only when no other agent has driven DEVSEL# first. The claim is held until the master signals the final data phase and that phase completes. Data transfer, parity and arbitration belong to neighbouring logic.

Top module: `pci_bar_decoder`

## Requirements
- R1: After reset, devsel_n is 1, claim_sub is 0 and claim_idx is 0. Every slot reads back only its fixed type bits.
- R2: A memory slot reads bit 0 as 0, bits 2:1 as 00 (32-bit) or 10 (64-bit), and bit 3 as its prefetchable flag. Bits below the window size read 0, so writing 0xFFFFFFFF returns the size mask. The upper-dword slot of a 64-bit window stores all 32 bits.
- R3: An I/O slot reads bit 0 as 1 and bit 1 as 0. Its address bits below the window size read 0.
- R4: The address and command are captured on the clock edge where frame_n is first seen low on an idle bus. Memory commands are C/BE# values 0110, 0111, 1100, 1110 and 1111. I/O commands are 0010 and 0011.
- R5: For a positive hit, devsel_n goes low on the 1st, 2nd or 3rd clock edge after the address edge. This is set by speed values 0, 1, and 2 or 3 respectively.
- R6: Memory commands match only memory slots, and only when mem_en is 1. I/O commands match only I/O slots, and only when io_en is 1. Any other command never claims positively.
- R7: Once claimed, devsel_n stays low while frame_n is low or the final data phase has not completed.
- R8: devsel_n returns to 1 on the clock edge where frame_n=1, irdy_n=0 and trdy_n=0 are observed together.
- R9: C/BE# value 1101 in the first address clock marks a dual address cycle. The low dword is captured with 1101, and the high dword and real command follow on the next clock. A 64-bit window hits only if the high dword equals its upper slot. A single-cycle address counts as high dword 0.
- R10: With sub_en=1 and no positive hit, devsel_n goes low with claim_sub=1 and claim_idx=0 on the 4th edge after the address edge. This happens only if devsel_ext_n was 1 at edges 1 through 4.
- R11: When several windows match, the lowest-numbered slot wins and is reported on claim_idx.
- R12: A transaction that is not claimed is ignored until frame_n and irdy_n are both seen high. Address changes during it cause no claim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for a base register |
| cfg_sel | input | 3 | Slot number for write and readback |
| cfg_wdata | input | 32 | Value written to the selected slot |
| cfg_rdata | output | 32 | Registered readback of the selected slot |
| mem_en | input | 1 | Memory space decode enable |
| io_en | input | 1 | I/O space decode enable |
| sub_en | input | 1 | Subtractive claim enable |
| speed | input | 2 | Claim timing: 0 fast, 1 medium, 2 or 3 slow |
| frame_n | input | 1 | Bus FRAME#, active low |
| irdy_n | input | 1 | Bus IRDY#, active low |
| trdy_n | input | 1 | Bus TRDY#, active low |
| ad | input | 32 | Bus address/data |
| cbe_n | input | 4 | Bus command / byte enables |
| devsel_ext_n | input | 1 | DEVSEL# as driven by other agents |
| devsel_n | output | 1 | This target's DEVSEL#, active low, registered |
| claim_sub | output | 1 | Current claim is subtractive |
| claim_idx | output | 3 | Slot that won the current positive claim |

## Verification
A corrupted stored base shows as a claim that is missing or extra. It appears on devsel_n within one to three edges of the next address phase, and on readback one clock after the slot is selected. A decode state machine stuck in the wrong state shows as a release that does not happen on the completion edge. It can also show as a claim on an edge other than the one set by speed, or as a subtractive claim despite an earlier external DEVSEL#. The stimulus moves addresses to the first and last byte of each window and one byte past it, to expose mask errors at the size boundary.

// File: rtl/pci_bar_pkg.sv
package pci_bar_pkg;
  localparam int NUM_BARS = 6;
  localparam int SEL_W    = 3;

  typedef enum logic [1:0] {
    BK_NONE  = 2'd0,
    BK_MEM32 = 2'd1,
    BK_MEM64 = 2'd2,
    BK_IO    = 2'd3
  } bar_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR2,
    ST_DECODE,
    ST_OWN,
    ST_SKIP
  } dec_state_e;

  localparam logic [3:0] CMD_DAC = 4'b1101;

  function automatic logic is_mem_cmd(input logic [3:0] c);
    return (c == 4'b0110) || (c == 4'b0111) || (c == 4'b1100) ||
           (c == 4'b1110) || (c == 4'b1111);
  endfunction

  function automatic logic is_io_cmd(input logic [3:0] c);
    return c[3:1] == 3'b001;
  endfunction

  // a slot is the upper dword when the slot below it is a 64-bit memory window
  function automatic logic is_upper_slot(input logic [2*NUM_BARS-1:0] kinds, input int i);
    if (i == 0) return 1'b0;
    return kinds[2*(i-1) +: 2] == BK_MEM64;
  endfunction
endpackage

// File: rtl/pci_bar_slot.sv
module pci_bar_slot
  import pci_bar_pkg::*;
#(
  parameter bar_kind_e KIND  = BK_NONE,
  parameter int        SZ    = 12,
  parameter bit        PREF  = 1'b0,
  parameter bit        UPPER = 1'b0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  input  logic [31:0] addr_lo,
  input  logic [31:0] addr_hi,
  input  logic [31:0] upper_val,
  input  logic        mem_ok,
  input  logic        io_ok,
  output logic [31:0] rd_val,
  output logic        hit
);
  localparam logic [31:0] SZ_MASK = ~((32'd1 << SZ) - 32'd1);
  localparam logic [31:0] WMASK   = UPPER ? 32'hFFFF_FFFF :
                                    (KIND == BK_NONE) ? 32'h0 : SZ_MASK;
  localparam logic [31:0] FIXED   = UPPER              ? 32'h0 :
                                    (KIND == BK_IO)    ? 32'h1 :
                                    (KIND == BK_MEM64) ? {28'h0, PREF, 3'b100} :
                                    (KIND == BK_MEM32) ? {28'h0, PREF, 3'b000} : 32'h0;

  logic [31:0] base_q;
  logic        base_match;

  always_ff @(posedge clk) begin
    if (rst)        base_q <= '0;
    else if (wr_en) base_q <= wdata & WMASK;
  end

  assign rd_val     = base_q | FIXED;
  assign base_match = (addr_lo & WMASK) == base_q;

  always_comb begin
    hit = 1'b0;
    if (!UPPER) begin
      case (KIND)
        BK_MEM32: hit = mem_ok && base_match && (addr_hi == 32'h0);
        BK_MEM64: hit = mem_ok && base_match && (addr_hi == upper_val);
        BK_IO:    hit = io_ok && base_match;
        default:  hit = 1'b0;
      endcase
    end
  end

  // a window only answers to commands of its own space class
  assert_cmd_space_R6: assert property (@(posedge clk) disable iff (rst)
    hit |-> ((KIND == BK_IO) ? io_ok : mem_ok));
endmodule

// File: rtl/pci_bar_claim.sv
module pci_bar_claim
  import pci_bar_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_n,
  input  logic             irdy_n,
  input  logic             trdy_n,
  input  logic             devsel_ext_n,
  input  logic [31:0]      ad,
  input  logic [3:0]       cbe_n,
  input  logic             sub_en,
  input  logic [1:0]       speed,
  input  logic             any_hit,
  input  logic [IDX_W-1:0] hit_idx,
  output logic [31:0]      dec_lo,
  output logic [31:0]      dec_hi,
  output logic [3:0]       dec_cmd,
  output logic             devsel_n,
  output logic             claim_sub,
  output logic [IDX_W-1:0] claim_idx
);
  localparam logic [2:0] SUB_EDGE = 3'd4;

  dec_state_e       st;
  logic [31:0]      lo_q;
  logic [2:0]       cnt;
  logic             hit_q;
  logic [IDX_W-1:0] idx_q;
  logic             seen_q;
  logic [2:0]       target;

  // in the second clock of a dual address cycle the low dword comes from the holding register
  assign dec_lo  = (st == ST_ADDR2) ? lo_q : ad;
  assign dec_hi  = (st == ST_ADDR2) ? ad   : 32'h0;
  assign dec_cmd = cbe_n;
  assign target  = (speed == 2'd0) ? 3'd1 : (speed == 2'd1) ? 3'd2 : 3'd3;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      lo_q      <= '0;
      cnt       <= '0;
      hit_q     <= 1'b0;
      idx_q     <= '0;
      seen_q    <= 1'b0;
      devsel_n  <= 1'b1;
      claim_sub <= 1'b0;
      claim_idx <= '0;
    end else begin
      case (st)
        ST_IDLE: if (!frame_n) begin
          if (cbe_n == CMD_DAC) begin
            lo_q <= ad;
            st   <= ST_ADDR2;
          end else begin
            hit_q  <= any_hit;
            idx_q  <= hit_idx;
            cnt    <= 3'd1;
            seen_q <= 1'b0;
            st     <= ST_DECODE;
          end
        end
        ST_ADDR2: begin
          hit_q  <= any_hit;
          idx_q  <= hit_idx;
          cnt    <= 3'd1;
          seen_q <= 1'b0;
          st     <= ST_DECODE;
        end
        ST_DECODE: begin
          cnt    <= cnt + 3'd1;
          seen_q <= seen_q | !devsel_ext_n;
          if (hit_q && cnt == target) begin
            devsel_n  <= 1'b0;
            claim_sub <= 1'b0;
            claim_idx <= idx_q;
            st        <= ST_OWN;
          end else if (cnt == SUB_EDGE) begin
            if (sub_en && !hit_q && !seen_q && devsel_ext_n) begin
              devsel_n  <= 1'b0;
              claim_sub <= 1'b1;
              claim_idx <= '0;
              st        <= ST_OWN;
            end else begin
              st <= ST_SKIP;
            end
          end
        end
        ST_OWN: if (frame_n && !irdy_n && !trdy_n) begin
          devsel_n  <= 1'b1;
          claim_sub <= 1'b0;
          st        <= ST_IDLE;
        end
        ST_SKIP: if (frame_n && irdy_n) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (devsel_n && !claim_sub));

  assert_claim_window_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(devsel_n) |-> ($past(cnt) >= 3'd1 && $past(cnt) <= SUB_EDGE));

  assert_hold_claim_R7: assert property (@(posedge clk) disable iff (rst)
    (!devsel_n && !frame_n) |=> !devsel_n);

  assert_release_R8: assert property (@(posedge clk) disable iff (rst)
    (!devsel_n && frame_n && !irdy_n && !trdy_n) |=> devsel_n);

  assert_sub_yield_R10: assert property (@(posedge clk) disable iff (rst)
    ($fell(devsel_n) && claim_sub) |-> $past(devsel_ext_n));
endmodule

// File: rtl/pci_bar_decoder.sv
module pci_bar_decoder
  import pci_bar_pkg::*;
#(
  // 2 bits per slot: 0 unused, 1 mem32, 2 mem64 (next slot holds upper dword), 3 I/O
  parameter logic [2*NUM_BARS-1:0] BAR_KIND = {2'd1, 2'd0, 2'd0, 2'd2, 2'd3, 2'd1},
  // 6 bits per slot: log2 of window size in bytes
  parameter logic [6*NUM_BARS-1:0] BAR_SZ   = {6'd8, 6'd0, 6'd0, 6'd20, 6'd5, 6'd12},
  parameter logic [NUM_BARS-1:0]   BAR_PREF = 6'b000100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  input  logic             mem_en,
  input  logic             io_en,
  input  logic             sub_en,
  input  logic [1:0]       speed,
  input  logic             frame_n,
  input  logic             irdy_n,
  input  logic             trdy_n,
  input  logic [31:0]      ad,
  input  logic [3:0]       cbe_n,
  input  logic             devsel_ext_n,
  output logic             devsel_n,
  output logic             claim_sub,
  output logic [SEL_W-1:0] claim_idx
);
  logic [31:0]         dec_lo, dec_hi;
  logic [3:0]          dec_cmd;
  logic                mem_ok, io_ok;
  logic [31:0]         slot_val [NUM_BARS+1];
  logic [NUM_BARS-1:0] hits;
  logic                any_hit;
  logic [SEL_W-1:0]    hit_idx;

  assign mem_ok             = mem_en && is_mem_cmd(dec_cmd);
  assign io_ok              = io_en && is_io_cmd(dec_cmd);
  assign slot_val[NUM_BARS] = 32'h0;

  for (genvar i = 0; i < NUM_BARS; i++) begin : g_bar
    localparam bar_kind_e KI = bar_kind_e'(BAR_KIND[2*i +: 2]);
    pci_bar_slot #(
      .KIND (KI),
      .SZ   (int'(BAR_SZ[6*i +: 6])),
      .PREF (BAR_PREF[i]),
      .UPPER(is_upper_slot(BAR_KIND, i))
    ) u_slot (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (cfg_wr && (cfg_sel == SEL_W'(i))),
      .wdata    (cfg_wdata),
      .addr_lo  (dec_lo),
      .addr_hi  (dec_hi),
      .upper_val(slot_val[i+1]),
      .mem_ok   (mem_ok),
      .io_ok    (io_ok),
      .rd_val   (slot_val[i]),
      .hit      (hits[i])
    );
  end

  // lowest-numbered matching slot wins
  always_comb begin
    any_hit = 1'b0;
    hit_idx = '0;
    for (int i = NUM_BARS - 1; i >= 0; i--) begin
      if (hits[i]) begin
        any_hit = 1'b1;
        hit_idx = SEL_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                          cfg_rdata <= '0;
    else if (int'(cfg_sel) < NUM_BARS) cfg_rdata <= slot_val[cfg_sel];
    else                              cfg_rdata <= '0;
  end

  pci_bar_claim #(.IDX_W(SEL_W)) u_claim (
    .clk         (clk),
    .rst         (rst),
    .frame_n     (frame_n),
    .irdy_n      (irdy_n),
    .trdy_n      (trdy_n),
    .devsel_ext_n(devsel_ext_n),
    .ad          (ad),
    .cbe_n       (cbe_n),
    .sub_en      (sub_en),
    .speed       (speed),
    .any_hit     (any_hit),
    .hit_idx     (hit_idx),
    .dec_lo      (dec_lo),
    .dec_hi      (dec_hi),
    .dec_cmd     (dec_cmd),
    .devsel_n    (devsel_n),
    .claim_sub   (claim_sub),
    .claim_idx   (claim_idx)
  );

  assert_single_winner_R11: assert property (@(posedge clk) disable iff (rst)
    $fell(devsel_n) && !claim_sub |-> (int'(claim_idx) < NUM_BARS));
endmodule

// File: tb/tb_pci_bar_decoder.sv
module tb_pci_bar_decoder;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_wr;
  logic [2:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        mem_en, io_en, sub_en;
  logic [1:0]  speed;
  logic        frame_n, irdy_n, trdy_n, devsel_ext_n;
  logic [31:0] ad;
  logic [3:0]  cbe_n;
  logic        devsel_n, claim_sub;
  logic [2:0]  claim_idx;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  pci_bar_decoder dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .mem_en(mem_en), .io_en(io_en), .sub_en(sub_en), .speed(speed),
    .frame_n(frame_n), .irdy_n(irdy_n), .trdy_n(trdy_n), .ad(ad), .cbe_n(cbe_n),
    .devsel_ext_n(devsel_ext_n), .devsel_n(devsel_n), .claim_sub(claim_sub),
    .claim_idx(claim_idx)
  );

  typedef struct packed {
    logic [1:0]  spd;
    logic        sub;
    logic        dac;
    logic [3:0]  cmd;
    logic [31:0] hi;
    logic [31:0] lo;
    logic [2:0]  ext;   // edge at which another agent drives DEVSEL#, 0 = never
    logic [2:0]  k;     // expected claim edge, 0 = no claim
    logic        esub;
    logic [2:0]  idx;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VT [NV] = '{
    '{2'd0, 1'b0, 1'b0, 4'h6, 32'h0, 32'h8000_0010, 3'd0, 3'd1, 1'b0, 3'd0}, // R5 fast
    '{2'd1, 1'b0, 1'b0, 4'h7, 32'h0, 32'h8000_0FFC, 3'd0, 3'd2, 1'b0, 3'd0}, // R5 medium, top of window
    '{2'd2, 1'b0, 1'b0, 4'h6, 32'h0, 32'h8000_1000, 3'd0, 3'd0, 1'b0, 3'd0}, // R6 one past window
    '{2'd2, 1'b0, 1'b0, 4'h2, 32'h0, 32'h0000_101C, 3'd0, 3'd3, 1'b0, 3'd1}, // R6 io hit slow
    '{2'd0, 1'b0, 1'b0, 4'h3, 32'h0, 32'h0000_1020, 3'd0, 3'd0, 1'b0, 3'd0}, // R6 io one past
    '{2'd0, 1'b0, 1'b0, 4'h6, 32'h0, 32'h0000_1000, 3'd0, 3'd0, 1'b0, 3'd0}, // R6 mem cmd on io range
    '{2'd0, 1'b0, 1'b0, 4'h2, 32'h0, 32'h8000_0010, 3'd0, 3'd0, 1'b0, 3'd0}, // R6 io cmd on mem range
    '{2'd1, 1'b0, 1'b1, 4'h6, 32'h2, 32'h400F_FFF0, 3'd0, 3'd2, 1'b0, 3'd2}, // R9 dual cycle hit
    '{2'd1, 1'b0, 1'b1, 4'h6, 32'h3, 32'h4000_0000, 3'd0, 3'd0, 1'b0, 3'd0}, // R9 wrong high dword
    '{2'd0, 1'b0, 1'b0, 4'h6, 32'h0, 32'h4000_0000, 3'd0, 3'd0, 1'b0, 3'd0}, // R9 single cycle, high 0
    '{2'd0, 1'b0, 1'b0, 4'h6, 32'h0, 32'h9000_0080, 3'd0, 3'd1, 1'b0, 3'd5}, // R5 slot 5
    '{2'd0, 1'b0, 1'b0, 4'hA, 32'h0, 32'h8000_0010, 3'd0, 3'd0, 1'b0, 3'd0}, // R6 config cmd ignored
    '{2'd0, 1'b1, 1'b0, 4'h6, 32'h0, 32'h1234_5678, 3'd0, 3'd4, 1'b1, 3'd0}, // R10 sub claim
    '{2'd0, 1'b1, 1'b0, 4'h6, 32'h0, 32'h1234_5678, 3'd2, 3'd0, 1'b0, 3'd0}, // R10 other agent edge 2
    '{2'd0, 1'b1, 1'b0, 4'h6, 32'h0, 32'h1234_5678, 3'd4, 3'd0, 1'b0, 3'd0}, // R10 other agent edge 4
    '{2'd2, 1'b1, 1'b0, 4'h6, 32'h0, 32'h8000_0010, 3'd0, 3'd3, 1'b0, 3'd0}, // R10 positive beats sub
    '{2'd0, 1'b1, 1'b0, 4'hC, 32'h0, 32'h8000_0020, 3'd0, 3'd1, 1'b0, 3'd0}, // R4 read multiple
    '{2'd3, 1'b0, 1'b0, 4'hF, 32'h0, 32'h9000_0000, 3'd0, 3'd3, 1'b0, 3'd5}  // R4 write-invalidate, R5 speed 3
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk); cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic cfg_read(input logic [2:0] sel, output logic [31:0] d);
    @(negedge clk); cfg_sel = sel;
    @(negedge clk); d = cfg_rdata;
  endtask

  task automatic run_txn(input logic dac, input logic [31:0] hi, input logic [31:0] lo,
                         input logic [3:0] cmd, input logic [2:0] ext,
                         output logic [2:0] first, output logic sub_o, output logic [2:0] idx_o,
                         output logic held, output logic rel);
    first = 3'd0; sub_o = 1'b0; idx_o = 3'd0; held = 1'b1; rel = 1'b1;
    @(negedge clk); frame_n = 1'b0; ad = lo; cbe_n = dac ? 4'hD : cmd;
    if (dac) begin
      @(negedge clk); ad = hi; cbe_n = cmd;
    end
    @(negedge clk); frame_n = 1'b1; irdy_n = 1'b0; ad = '0; cbe_n = 4'h0;
    for (int k = 1; k <= 5; k++) begin
      devsel_ext_n = !(ext != 3'd0 && k >= int'(ext));
      @(negedge clk);
      if (!devsel_n && first == 3'd0) begin
        first = 3'(k); sub_o = claim_sub; idx_o = claim_idx;
      end else if (first != 3'd0 && devsel_n) begin
        held = 1'b0;
      end
    end
    devsel_ext_n = 1'b1;
    if (first != 3'd0) begin
      trdy_n = 1'b0;
      @(negedge clk);
      rel = devsel_n;
      trdy_n = 1'b1;
    end
    irdy_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [2:0]  first, idx_o;
    logic        sub_o, held, rel;

    rst = 1'b1; cfg_wr = 1'b0; cfg_sel = 3'd0; cfg_wdata = '0;
    mem_en = 1'b1; io_en = 1'b1; sub_en = 1'b0; speed = 2'd0;
    frame_n = 1'b1; irdy_n = 1'b1; trdy_n = 1'b1; devsel_ext_n = 1'b1;
    ad = '0; cbe_n = 4'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1", "devsel_n", 32'(devsel_n), 32'h1);
    chk("R1", "claim_sub", 32'(claim_sub), 32'h0);
    chk("R1", "claim_idx", 32'(claim_idx), 32'h0);
    cfg_read(3'd0, rd); chk("R1", "slot0", rd, 32'h0);
    cfg_read(3'd1, rd); chk("R1", "slot1 io bit", rd, 32'h1);
    cfg_read(3'd2, rd); chk("R1", "slot2 type", rd, 32'hC);

    // R2 R3 size probing
    for (int s = 0; s < 6; s++) cfg_write(3'(s), 32'hFFFF_FFFF);
    cfg_read(3'd0, rd); chk("R2", "slot0 mask", rd, 32'hFFFF_F000);
    cfg_read(3'd1, rd); chk("R3", "slot1 mask", rd, 32'hFFFF_FFE1);
    cfg_read(3'd2, rd); chk("R2", "slot2 mask", rd, 32'hFFF0_000C);
    cfg_read(3'd3, rd); chk("R2", "slot3 upper", rd, 32'hFFFF_FFFF);
    cfg_read(3'd4, rd); chk("R2", "slot4 unused", rd, 32'h0);
    cfg_read(3'd5, rd); chk("R2", "slot5 mask", rd, 32'hFFFF_FF00);

    // program windows
    cfg_write(3'd0, 32'h8000_0000);
    cfg_write(3'd1, 32'h0000_1003);
    cfg_write(3'd2, 32'h4000_0000);
    cfg_write(3'd3, 32'h0000_0002);
    cfg_write(3'd4, 32'h0);
    cfg_write(3'd5, 32'h9000_0000);
    cfg_read(3'd1, rd); chk("R3", "slot1 base", rd, 32'h0000_1001);
    cfg_read(3'd2, rd); chk("R2", "slot2 base", rd, 32'h4000_000C);

    // vector table: R4 R5 R6 R9 R10
    for (int v = 0; v < NV; v++) begin
      speed = VT[v].spd; sub_en = VT[v].sub;
      run_txn(VT[v].dac, VT[v].hi, VT[v].lo, VT[v].cmd, VT[v].ext, first, sub_o, idx_o, held, rel);
      chk("R5 R6 R9 R10", $sformatf("vec %0d claim edge", v), 32'(first), 32'(VT[v].k));
      if (VT[v].k != 3'd0) begin
        chk("R10", $sformatf("vec %0d claim_sub", v), 32'(sub_o), 32'(VT[v].esub));
        chk("R11", $sformatf("vec %0d claim_idx", v), 32'(idx_o), 32'(VT[v].idx));
        chk("R7", $sformatf("vec %0d held", v), 32'(held), 32'h1);
        chk("R8", $sformatf("vec %0d released", v), 32'(rel), 32'h1);
      end
    end
    sub_en = 1'b0; speed = 2'd0;

    // R6 space enables
    mem_en = 1'b0;
    run_txn(1'b0, 32'h0, 32'h8000_0010, 4'h6, 3'd0, first, sub_o, idx_o, held, rel);
    chk("R6", "mem_en off", 32'(first), 32'h0);
    mem_en = 1'b1; io_en = 1'b0;
    run_txn(1'b0, 32'h0, 32'h0000_1004, 4'h2, 3'd0, first, sub_o, idx_o, held, rel);
    chk("R6", "io_en off", 32'(first), 32'h0);
    io_en = 1'b1;

    // R7 R8 burst: claim held through data phases, released on completion edge
    @(negedge clk); frame_n = 1'b0; ad = 32'h8000_0100; cbe_n = 4'h6;
    @(negedge clk); irdy_n = 1'b0; ad = '0; cbe_n = 4'h0;
    @(negedge clk); chk("R5", "burst claim", 32'(devsel_n), 32'h0);
    trdy_n = 1'b0;
    @(negedge clk); chk("R7", "burst hold 1", 32'(devsel_n), 32'h0);
    @(negedge clk); chk("R7", "burst hold 2", 32'(devsel_n), 32'h0);
    frame_n = 1'b1;
    @(negedge clk); chk("R8", "release edge", 32'(devsel_n), 32'h1);
    irdy_n = 1'b1; trdy_n = 1'b1;
    @(negedge clk);

    // R12 unclaimed burst ignored even when the address moves into a window
    @(negedge clk); frame_n = 1'b0; ad = 32'h1234_5678; cbe_n = 4'h6;
    @(negedge clk); irdy_n = 1'b0; ad = 32'h8000_0010;
    held = 1'b1;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      if (!devsel_n) held = 1'b0;
    end
    chk("R12", "no claim mid burst", 32'(held), 32'h1);
    frame_n = 1'b1; irdy_n = 1'b1;
    repeat (2) @(negedge clk);
    run_txn(1'b0, 32'h0, 32'h8000_0010, 4'h6, 3'd0, first, sub_o, idx_o, held, rel);
    chk("R4", "decode after idle", 32'(first), 32'h1);

    // R11 overlap: slot 5 moved onto slot 0's window
    cfg_write(3'd5, 32'h8000_0000);
    run_txn(1'b0, 32'h0, 32'h8000_0010, 4'h6, 3'd0, first, sub_o, idx_o, held, rel);
    chk("R11", "overlap claim", 32'(first), 32'h1);
    chk("R11", "overlap winner", 32'(idx_o), 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule